// File: doc/BRIEF.md
# Programmable Occupancy Flag Generator

This block turns the write and read pointers of a dual-clock FIFO into three active-low level flags: almost-full, almost-empty and half-full. The almost-full and almost-empty thresholds come from two run-time offsets. A mode input moves every threshold by one word when the FIFO runs with a look-ahead output register, because that register adds one word of capacity.

Each programmable flag has its own timing select. In tracking timing, the flag follows its condition on one clock only. In split timing, the clock that fills toward the condition asserts the flag and the opposite clock releases it. The half-full flag always uses split timing. It is asserted by the write clock and released by the read clock.

The pointers are free-running word counts of `PTR_W` bits, where `PTR_W = $clog2(DEPTH+1)+1`. The FIFO that hosts the block provides pointers that are already valid in both clock domains. Each flag is registered, so it reacts at the first enabled clock edge that sees the new pointers.

Top module: `prog_flags`

## Requirements
- R1: While `rst` is high across an edge of both clocks, `af_n` reads 1, `ae_n` reads 0 and `hf_n` reads 1.
- R2: The stored word count is `(wr_ptr - rd_ptr) mod 2^PTR_W`. The almost-full condition holds when this count is at least `CAP - af_offset`. `CAP` is `DEPTH` when `fwft_mode` = 0 and `DEPTH+1` when `fwft_mode` = 1.
- R3: With `af_split` = 0, every rising `wclk` edge loads `af_n` with the inverse of the almost-full condition. Rising `rclk` edges leave `af_n` unchanged.
- R4: With `af_split` = 1, a rising `wclk` edge that sees the almost-full condition drives `af_n` to 0. A rising `rclk` edge that sees the condition false drives `af_n` to 1. Otherwise `af_n` holds.
- R5: The almost-empty condition holds when the stored count is at most `ae_offset` (when `fwft_mode` = 0) or at most `ae_offset + 1` (when `fwft_mode` = 1).
- R6: With `ae_split` = 0, every rising `rclk` edge loads `ae_n` with the inverse of the almost-empty condition. Rising `wclk` edges leave `ae_n` unchanged.
- R7: With `ae_split` = 1, a rising `rclk` edge that sees the almost-empty condition drives `ae_n` to 0. A rising `wclk` edge that sees the condition false drives `ae_n` to 1.
- R8: A rising `wclk` edge that sees more than `DEPTH/2` stored words drives `hf_n` to 0.
- R9: A rising `rclk` edge that sees at most `DEPTH/2` stored words drives `hf_n` to 1.
- R10: Threshold arithmetic saturates. An `af_offset` of at least `CAP` makes the almost-full condition always true. An `ae_offset` of at least `DEPTH+1` makes the almost-empty condition always true. Neither case wraps around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| fwft_mode | input | 1 | 1 = look-ahead output register present; capacity grows by one word |
| af_split | input | 1 | Almost-full timing: 0 tracking on `wclk`, 1 split set/release |
| ae_split | input | 1 | Almost-empty timing: 0 tracking on `rclk`, 1 split set/release |
| af_offset | input | PTR_W | Almost-full offset m |
| ae_offset | input | PTR_W | Almost-empty offset n |
| wr_ptr | input | PTR_W | Free-running count of words written |
| rd_ptr | input | PTR_W | Free-running count of words read |
| af_n | output | 1 | Almost-full flag, active low |
| ae_n | output | 1 | Almost-empty flag, active low |
| hf_n | output | 1 | Half-full flag, active low |

## Verification
The checker checks on every edge of its own clock that a tracking-mode flag equals its condition from the previous edge. It also checks the reset values and that a saturating offset keeps its flag asserted.

Split timing needs a different kind of test, because there the answer depends on which clock ticked. The bench gates each clock on its own. It then shows that a read-only edge releases almost-full and a write-only edge releases almost-empty in split timing but not in tracking timing. The bench also covers the FWFT shift of one word, the exact threshold crossings for each flag, and pointer wrap.

// File: rtl/prog_flag_pkg.sv
package prog_flag_pkg;

    localparam int FLAG_AF  = 0;
    localparam int FLAG_AE  = 1;
    localparam int FLAG_HF  = 2;
    localparam int NUM_FLAGS = 3;

    // flags whose reset state is "asserted"
    localparam logic [NUM_FLAGS-1:0] INIT_ASSERTED = 3'b010;

    typedef struct packed {
        logic hf;
        logic ae;
        logic af;
    } flag_hits_t;

    typedef struct packed {
        logic fwft;
        logic af_split;
        logic ae_split;
    } flag_mode_t;

    function automatic logic [31:0] sat_sub(input logic [31:0] a, input logic [31:0] b);
        return (b >= a) ? 32'd0 : (a - b);
    endfunction

    function automatic logic [31:0] sat_add(input logic [31:0] a, input logic [31:0] b);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[32] ? 32'hFFFF_FFFF : s[31:0];
    endfunction

endpackage

// File: rtl/prog_flag_occ.sv
module prog_flag_occ
    import prog_flag_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = 6
) (
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [PTR_W-1:0] af_ofs,
    input  logic [PTR_W-1:0] ae_ofs,
    input  flag_mode_t       mode,
    output flag_hits_t       hits
);
    localparam logic [31:0] HALF = 32'(DEPTH / 2);

    logic [PTR_W-1:0] occ;
    logic [31:0]      occ_w;
    logic [31:0]      cap;
    logic [31:0]      af_thr;
    logic [31:0]      ae_thr;

    always_comb begin
        occ    = wr_ptr - rd_ptr;
        occ_w  = 32'(occ);
        cap    = 32'(DEPTH) + 32'(mode.fwft);
        af_thr = sat_sub(cap, 32'(af_ofs));
        ae_thr = sat_add(32'(ae_ofs), 32'(mode.fwft));
        hits.af = (occ_w >= af_thr);
        hits.ae = (occ_w <= ae_thr);
        hits.hf = (occ_w > HALF);
    end
endmodule

// File: rtl/prog_flag_cell.sv
module prog_flag_cell #(
    parameter bit INIT_LOW = 1'b0
) (
    input  logic set_clk,
    input  logic clr_clk,
    input  logic rst,
    input  logic split_en,
    input  logic hit,
    output logic flag_n
);
    logic set_tog;
    logic clr_tog;
    logic asserted;

    assign asserted = set_tog ^ clr_tog ^ INIT_LOW;
    assign flag_n   = ~asserted;

    // owning clock: sets in split timing, tracks in single-clock timing
    always_ff @(posedge set_clk) begin
        if (rst)
            set_tog <= 1'b0;
        else if (split_en ? (hit && !asserted) : (hit != asserted))
            set_tog <= ~set_tog;
    end

    // opposite clock: releases only in split timing
    always_ff @(posedge clr_clk) begin
        if (rst)
            clr_tog <= 1'b0;
        else if (split_en && asserted && !hit)
            clr_tog <= ~clr_tog;
    end
endmodule

// File: rtl/prog_flags.sv
module prog_flags
    import prog_flag_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH + 1) + 1
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst,
    input  logic             fwft_mode,
    input  logic             af_split,
    input  logic             ae_split,
    input  logic [PTR_W-1:0] af_offset,
    input  logic [PTR_W-1:0] ae_offset,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic             af_n,
    output logic             ae_n,
    output logic             hf_n
);
    flag_mode_t mode;
    flag_hits_t hits;

    logic [NUM_FLAGS-1:0] set_clk_v;
    logic [NUM_FLAGS-1:0] clr_clk_v;
    logic [NUM_FLAGS-1:0] split_v;
    logic [NUM_FLAGS-1:0] hit_v;
    logic [NUM_FLAGS-1:0] flag_v;

    assign mode = '{fwft: fwft_mode, af_split: af_split, ae_split: ae_split};

    prog_flag_occ #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_occ (
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .af_ofs (af_offset),
        .ae_ofs (ae_offset),
        .mode   (mode),
        .hits   (hits)
    );

    // per-flag clock roles: the filling side asserts, the draining side releases
    assign set_clk_v[FLAG_AF] = wclk;
    assign clr_clk_v[FLAG_AF] = rclk;
    assign split_v[FLAG_AF]   = mode.af_split;
    assign hit_v[FLAG_AF]     = hits.af;

    assign set_clk_v[FLAG_AE] = rclk;
    assign clr_clk_v[FLAG_AE] = wclk;
    assign split_v[FLAG_AE]   = mode.ae_split;
    assign hit_v[FLAG_AE]     = hits.ae;

    assign set_clk_v[FLAG_HF] = wclk;
    assign clr_clk_v[FLAG_HF] = rclk;
    assign split_v[FLAG_HF]   = 1'b1;
    assign hit_v[FLAG_HF]     = hits.hf;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        prog_flag_cell #(.INIT_LOW(INIT_ASSERTED[g])) u_cell (
            .set_clk  (set_clk_v[g]),
            .clr_clk  (clr_clk_v[g]),
            .rst      (rst),
            .split_en (split_v[g]),
            .hit      (hit_v[g]),
            .flag_n   (flag_v[g])
        );
    end

    assign af_n = flag_v[FLAG_AF];
    assign ae_n = flag_v[FLAG_AE];
    assign hf_n = flag_v[FLAG_HF];
endmodule

// File: rtl/prog_flags_chk.sv
module prog_flags_chk #(
    parameter int DEPTH = 16,
    parameter int OFS_W = 6
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst,
    input logic             af_split,
    input logic             ae_split,
    input logic [OFS_W-1:0] af_offset,
    input logic [OFS_W-1:0] ae_offset,
    input logic             af_hit,
    input logic             ae_hit,
    input logic             af_n,
    input logic             ae_n,
    input logic             hf_n
);
    logic [1:0] rst_cnt = 2'd0;

    always_ff @(posedge wclk) begin
        if (!rst)
            rst_cnt <= 2'd0;
        else if (rst_cnt != 2'd3)
            rst_cnt <= rst_cnt + 2'd1;
    end

    // R1: reset values once a reset edge has passed
    a_r1_reset_values: assert property (@(posedge wclk)
        (rst && rst_cnt >= 2'd1) |-> (af_n && !ae_n && hf_n));

    // R3: tracking almost-full equals last write-edge condition
    a_r3_af_tracks: assert property (@(posedge wclk) disable iff (rst)
        (!$past(rst) && !$past(af_split) && !af_split) |-> (af_n == !$past(af_hit)));

    // R6: tracking almost-empty equals last read-edge condition
    a_r6_ae_tracks: assert property (@(posedge rclk) disable iff (rst)
        (!$past(rst) && !$past(ae_split) && !ae_split) |-> (ae_n == !$past(ae_hit)));

    // R10: saturated full offset keeps almost-full asserted
    a_r10_af_saturated: assert property (@(posedge wclk) disable iff (rst)
        (!$past(rst) && ($past(af_offset) > DEPTH) && (af_offset > DEPTH)) |-> !af_n);

    // R10: saturated empty offset keeps almost-empty asserted
    a_r10_ae_saturated: assert property (@(posedge rclk) disable iff (rst)
        (!$past(rst) && ($past(ae_offset) > DEPTH) && (ae_offset > DEPTH)) |-> !ae_n);
endmodule

bind prog_flags prog_flags_chk #(.DEPTH(DEPTH), .OFS_W(PTR_W)) u_chk (
    .wclk      (wclk),
    .rclk      (rclk),
    .rst       (rst),
    .af_split  (af_split),
    .ae_split  (ae_split),
    .af_offset (af_offset),
    .ae_offset (ae_offset),
    .af_hit    (hits.af),
    .ae_hit    (hits.ae),
    .af_n      (af_n),
    .ae_n      (ae_n),
    .hf_n      (hf_n)
);

// File: tb/prog_flags_test.sv
module prog_flags_test;
    localparam int D  = 16;
    localparam int PW = $clog2(D + 1) + 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic wg = 1'b0, rg = 1'b0;
    logic wclk, rclk;
    assign wclk = clk & wg;
    assign rclk = clk & rg;

    logic rst = 1'b1;
    logic fwft = 1'b0, afs = 1'b0, aes = 1'b0;
    logic [PW-1:0] mo = '0, no = '0, wp = '0, rp = '0;
    logic af_n, ae_n, hf_n;

    int wr_i = 0, rd_i = 0;
    bit af_low = 1'b0, ae_low = 1'b1, hf_low = 1'b0;
    int checks = 0, fails = 0;
    string tag = "R1";
    bit done = 1'b0;

    prog_flags #(.DEPTH(D)) uut (
        .wclk(wclk), .rclk(rclk), .rst(rst), .fwft_mode(fwft),
        .af_split(afs), .ae_split(aes), .af_offset(mo), .ae_offset(no),
        .wr_ptr(wp), .rd_ptr(rp), .af_n(af_n), .ae_n(ae_n), .hf_n(hf_n)
    );

    function automatic int occ();
        return (wr_i - rd_i) & ((1 << PW) - 1);
    endfunction

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b (occ %0d)", req, what, got, exp, occ());
        end
    endtask

    task automatic cfg(input logic f, input logic a, input logic e, input int m, input int n);
        @(negedge clk);
        wg = 1'b0; rg = 1'b0;
        fwft = f; afs = a; aes = e; mo = PW'(m); no = PW'(n);
    endtask

    task automatic set_rst(input logic v);
        @(negedge clk);
        wg = 1'b0; rg = 1'b0; rst = v;
    endtask

    // one cycle: pointers move before the edge, the chosen clocks tick
    task automatic step(input bit w, input bit r, input int dw, input int dr);
        int o, cap, at;
        bit afh, aeh, hfh, na, ne, nh;
        @(negedge clk);
        wr_i += dw; rd_i += dr;
        wp = wr_i[PW-1:0]; rp = rd_i[PW-1:0];
        wg = w; rg = r;
        @(posedge clk);
        o   = occ();
        cap = D + int'(fwft);
        at  = (int'(mo) >= cap) ? 0 : cap - int'(mo);
        afh = (o >= at);
        aeh = (o <= int'(no) + int'(fwft));
        hfh = (o > D / 2);
        na = af_low; ne = ae_low; nh = hf_low;
        if (rst) begin
            if (w && r) begin na = 1'b0; ne = 1'b1; nh = 1'b0; end
        end else begin
            if (w) begin
                if (afs) begin if (afh) na = 1'b1; end else na = afh;
                if (hfh) nh = 1'b1;
                if (aes && !aeh) ne = 1'b0;
            end
            if (r) begin
                if (aes) begin if (aeh) ne = 1'b1; end else ne = aeh;
                if (!hfh) nh = 1'b0;
                if (afs && !afh) na = 1'b0;
            end
        end
        af_low = na; ae_low = ne; hf_low = nh;
        #2;
        chk(af_n, !af_low, tag, "model af_n");
        chk(ae_n, !ae_low, tag, "model ae_n");
        chk(hf_n, !hf_low, tag, "model hf_n");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset
        tag = "R1";
        step(1, 1, 0, 0);
        step(1, 1, 0, 0);
        chk(af_n, 1'b1, "R1", "reset af_n");
        chk(ae_n, 1'b0, "R1", "reset ae_n");
        chk(hf_n, 1'b1, "R1", "reset hf_n");
        set_rst(1'b0);

        // standard mode, tracking timing: threshold crossings on fill
        cfg(0, 0, 0, 3, 2);
        tag = "R3";
        for (int i = 0; i < D; i++) begin
            step(1, 1, 1, 0);
            if (occ() == 12) chk(af_n, 1'b1, "R2", "af_n below D-m");
            if (occ() == 13) chk(af_n, 1'b0, "R2", "af_n at D-m");
            if (occ() == 2)  chk(ae_n, 1'b0, "R5", "ae_n at n");
            if (occ() == 3)  chk(ae_n, 1'b1, "R5", "ae_n above n");
            if (occ() == 8)  chk(hf_n, 1'b1, "R8", "hf_n at half");
            if (occ() == 9)  chk(hf_n, 1'b0, "R8", "hf_n above half");
        end
        tag = "R6";
        for (int i = 0; i < D; i++) step(1, 1, 0, 1);

        // tracking timing: opposite clock has no effect
        tag = "R3";
        for (int i = 0; i < D; i++) step(1, 1, 1, 0);
        step(0, 1, 0, 5);
        chk(af_n, 1'b0, "R3", "af_n held on read edge");
        step(1, 0, 0, 0);
        chk(af_n, 1'b1, "R3", "af_n released on write edge");
        tag = "R6";
        step(0, 1, 0, 10);
        chk(ae_n, 1'b0, "R6", "ae_n set on read edge");
        step(1, 0, 4, 0);
        chk(ae_n, 1'b0, "R6", "ae_n held on write edge");
        step(0, 1, 0, 0);
        chk(ae_n, 1'b1, "R6", "ae_n released on read edge");

        // split timing
        cfg(0, 1, 1, 3, 2);
        tag = "R4";
        step(1, 0, 10, 0);
        chk(af_n, 1'b0, "R4", "af_n set on write edge");
        step(0, 1, 0, 5);
        chk(af_n, 1'b1, "R4", "af_n released on read edge");
        tag = "R7";
        step(0, 1, 0, 9);
        chk(ae_n, 1'b0, "R7", "ae_n set on read edge");
        step(1, 0, 3, 0);
        chk(ae_n, 1'b1, "R7", "ae_n released on write edge");

        // half-full
        tag = "R9";
        step(1, 0, 6, 0);
        chk(hf_n, 1'b0, "R8", "hf_n set on write edge");
        step(0, 1, 0, 2);
        chk(hf_n, 1'b1, "R9", "hf_n released on read edge");
        step(0, 1, 0, 8);

        // FWFT shift
        cfg(1, 0, 0, 3, 2);
        tag = "R5";
        for (int i = 0; i < D + 1; i++) begin
            step(1, 1, 1, 0);
            if (occ() == 13) chk(af_n, 1'b1, "R2", "fwft af_n below D+1-m");
            if (occ() == 14) chk(af_n, 1'b0, "R2", "fwft af_n at D+1-m");
            if (occ() == 3)  chk(ae_n, 1'b0, "R5", "fwft ae_n at n+1");
            if (occ() == 4)  chk(ae_n, 1'b1, "R5", "fwft ae_n above n+1");
        end
        for (int i = 0; i < D + 1; i++) step(1, 1, 0, 1);

        // saturation
        cfg(0, 0, 0, 40, 60);
        tag = "R10";
        step(1, 1, 0, 0);
        chk(af_n, 1'b0, "R10", "large m, empty");
        step(1, 1, D, 0);
        chk(af_n, 1'b0, "R10", "large m, full");
        chk(ae_n, 1'b0, "R10", "large n, full");
        step(1, 1, 0, D);
        cfg(1, 0, 0, 63, 63);
        for (int i = 0; i < D + 1; i++) step(1, 1, 1, 0);
        chk(ae_n, 1'b0, "R10", "max n fwft, full");
        chk(af_n, 1'b0, "R10", "max m fwft, full");
        for (int i = 0; i < D + 1; i++) step(1, 1, 0, 1);

        // pointer wrap
        cfg(0, 0, 0, 3, 2);
        tag = "R2";
        step(1, 1, 10, 0);
        for (int i = 0; i < 70; i++) step(1, 1, 1, 1);
        chk(hf_n, 1'b0, "R2", "hf_n after wrap");
        chk(af_n, 1'b1, "R2", "af_n after wrap");
        step(1, 1, 0, 10);
        chk(ae_n, 1'b0, "R2", "ae_n empty after wrap");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule